// File: doc/BRIEF.md
# Class-D Power-Stage Protection Supervisor

This block is the digital supervisor for a power stage made of four half-bridges grouped in two pairs. It takes synchronized fault flags: one overcurrent flag per pair, a temperature warning flag, a temperature error flag, one undervoltage flag per monitored supply, and a power-on reset flag. From these it drives, for each pair, a high-impedance command to the gate drivers and an enable for the weak output pulldowns. It also drives two active-low status pins that together encode the fault class.

Persistent overcurrent is counted in PWM frames, using a frame-tick strobe. When it has lasted long enough it becomes a latched overload that stops only the offending pair. A temperature error is latched and stops every pair. Undervoltage and power-on reset stop every pair and release by themselves. Each latched fault has its own clearing rule, tied to the two active-low pair reset inputs. The pair resets, the frame tick and the mode code are synchronous to `clk`. The fault flags are asynchronous and pass through a synchronizer chain.

Top module: `pstage_guard`

## Requirements
- R1: Leaving reset with no fault present and both pair resets high gives all high-impedance commands 0, all pulldown enables 0, `shutdown_n` = 1 and `warn_n` = 1.
- R2: A fault flag takes effect two clock edges after it is sampled, through a synchronizer of depth `SYNC_STAGES` (default 2). One edge after the change, the outputs still show the old state.
- R3: When a pair's overcurrent flag is seen in `OLP_FRAMES` consecutive frames, an overload is latched on that pair only. The pair goes high-impedance and the other pair is not affected. Fewer consecutive frames latch nothing. A frame ends on a cycle where `frame_tick` is 1.
- R4: The overload frame count returns to zero after any frame in which the pair's overcurrent flag was never seen.
- R5: A latched overload clears only on a rising edge of that pair's own reset input. A reset pulse on the other pair leaves it latched.
- R6: Power-on reset holds every pair high-impedance while it is present and clears any latched overload. It releases automatically.
- R7: A temperature error is latched and holds every pair high-impedance. It clears only in a cycle in which both pair resets are low together and the error flag is gone. A low level on one pair reset alone does not clear it.
- R8: Any undervoltage supply flag holds every pair high-impedance. Release is automatic once all supply flags are low.
- R9: Status code {`shutdown_n`,`warn_n`} is as follows. 00 means a temperature error is latched. 01 means an overload, undervoltage or power-on reset is present without a temperature warning. 10 means a temperature warning only. 11 means normal operation.
- R10: While either pair reset is low, `shutdown_n` is 1 whatever faults are present.
- R11: A low pair reset puts that pair in high impedance. It also enables that pair's pulldowns, unless `mode` is 3'b100 (single-ended), in which case the pulldowns stay off. All other codes count as bridge-tied for this purpose.
- R12: `warn_n` follows the synchronized temperature warning flag directly, with no hysteresis added by the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| frame_tick | input | 1 | One-cycle strobe that ends each PWM frame |
| oc_flag | input | NPAIR | Overcurrent flag per bridge pair (asynchronous) |
| otw_flag | input | 1 | Temperature warning comparator flag (asynchronous) |
| ote_flag | input | 1 | Temperature error comparator flag (asynchronous) |
| uv_flag | input | NSUP | Undervoltage flag per monitored supply (asynchronous) |
| por_flag | input | 1 | Power-on reset flag (asynchronous) |
| pair_rst_n | input | NPAIR | Active-low reset per bridge pair |
| mode | input | 3 | Output configuration code; 3'b100 is single-ended |
| hiz_o | output | NPAIR | High-impedance command per pair |
| pulldown_en_o | output | NPAIR | Weak output pulldown enable per pair |
| shutdown_n | output | 1 | Active-low shutdown status |
| warn_n | output | 1 | Active-low temperature warning status |

## Verification
The hardest state to reach is an overload that latches on exactly the frame where the count reaches its limit. This is hard because the overcurrent flag passes through the synchronizer while the frame boundary does not. The bench changes the overcurrent input exactly two edges before each frame-ending tick, so each frame sees one clean value. It then sweeps the run length from one frame past the limit on each pair. A second pattern places a single quiet frame between two runs that are each one frame short, which shows that the count restarts.

// File: rtl/pstage_guard_pkg.sv
package pstage_guard_pkg;
   // Width of the configuration code and the code that selects single-ended outputs.
   localparam int MODE_W = 3;
   localparam logic [MODE_W-1:0] MODE_SINGLE_ENDED = 3'b100;

   function automatic logic is_single_ended(input logic [MODE_W-1:0] code);
      return code == MODE_SINGLE_ENDED;
   endfunction
endpackage

// File: rtl/pg_sync.sv
module pg_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("pg_sync: STAGES must be at least 2");
      end
      if (W < 1) begin : g_bad_width
         $error("pg_sync: W must be at least 1");
      end
   endgenerate

   logic [W-1:0] chain_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) chain_q[i] <= '0;
      end else begin
         chain_q[0] <= d;
         for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
      end
   end

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/pg_olp_track.sv
module pg_olp_track #(
   parameter int OLP_FRAMES = 480
) (
   input  logic clk,
   input  logic rst_n,
   input  logic frame_tick,
   input  logic oc,
   input  logic pair_rst_n,
   input  logic hold,
   input  logic por,
   output logic olp
);
   localparam int CW = (OLP_FRAMES > 2) ? $clog2(OLP_FRAMES) : 1;
   localparam logic [CW-1:0] LAST = CW'(OLP_FRAMES - 1);

   generate
      if (OLP_FRAMES < 2) begin : g_bad_limit
         $error("pg_olp_track: OLP_FRAMES must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt_q;
   logic          seen_q;
   logic          olp_q;
   logic          prst_q;
   logic          rst_rise;
   logic          frame_oc;
   logic          freeze;
   logic          declare;

   always_comb begin
      rst_rise = pair_rst_n & ~prst_q;
      frame_oc = seen_q | oc;
      freeze   = por | ~pair_rst_n | olp_q | hold;
      declare  = ~freeze & frame_tick & frame_oc & (cnt_q == LAST);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         seen_q <= 1'b0;
         olp_q  <= 1'b0;
         prst_q <= 1'b1;
      end else begin
         prst_q <= pair_rst_n;
         if (por || rst_rise)  olp_q <= 1'b0;
         else if (declare)     olp_q <= 1'b1;
         if (freeze) begin
            cnt_q  <= '0;
            seen_q <= 1'b0;
         end else if (frame_tick) begin
            seen_q <= 1'b0;
            if (!frame_oc || declare) cnt_q <= '0;
            else                      cnt_q <= cnt_q + 1'b1;
         end else if (oc) begin
            seen_q <= 1'b1;
         end
      end
   end

   assign olp = olp_q;

   // R3
   olp_set_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(olp_q) |-> $past(frame_tick));
   // R5
   olp_clear_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(olp_q) |-> $past(rst_rise || por));
   // R6
   por_clears_olp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      por |=> !olp_q);
endmodule

// File: rtl/pg_ote_latch.sv
module pg_ote_latch #(
   parameter int NPAIR = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ote,
   input  logic [NPAIR-1:0] pair_rst_n,
   output logic             ote_lat
);
   logic lat_q;
   logic all_low;

   assign all_low = (pair_rst_n == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       lat_q <= 1'b0;
      else if (ote)     lat_q <= 1'b1;
      else if (all_low) lat_q <= 1'b0;
   end

   assign ote_lat = lat_q;

   // R7
   ote_clear_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(lat_q) |-> $past(pair_rst_n == '0));
endmodule

// File: rtl/pstage_guard.sv
module pstage_guard
   import pstage_guard_pkg::*;
#(
   parameter int NPAIR       = 2,
   parameter int NSUP        = 2,
   parameter int OLP_FRAMES  = 480,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_tick,
   input  logic [NPAIR-1:0]  oc_flag,
   input  logic              otw_flag,
   input  logic              ote_flag,
   input  logic [NSUP-1:0]   uv_flag,
   input  logic              por_flag,
   input  logic [NPAIR-1:0]  pair_rst_n,
   input  logic [MODE_W-1:0] mode,
   output logic [NPAIR-1:0]  hiz_o,
   output logic [NPAIR-1:0]  pulldown_en_o,
   output logic              shutdown_n,
   output logic              warn_n
);
   localparam int FW = NPAIR + NSUP + 3;

   generate
      if (NPAIR < 1) begin : g_bad_pairs
         $error("pstage_guard: NPAIR must be at least 1");
      end
      if (NSUP < 1) begin : g_bad_sup
         $error("pstage_guard: NSUP must be at least 1");
      end
   endgenerate

   logic [FW-1:0]    raw_flags;
   logic [FW-1:0]    syn_flags;
   logic [NPAIR-1:0] oc_s;
   logic [NSUP-1:0]  uv_s;
   logic             otw_s, ote_s, por_s;
   logic             ote_lat;
   logic             uv_any;
   logic             global_flt;
   logic             se_mode;
   logic [NPAIR-1:0] olp;

   assign raw_flags = {por_flag, ote_flag, otw_flag, uv_flag, oc_flag};

   pg_sync #(.W(FW), .STAGES(SYNC_STAGES)) flag_sync_i (
      .clk(clk), .rst_n(rst_n), .d(raw_flags), .q(syn_flags)
   );

   assign oc_s  = syn_flags[NPAIR-1:0];
   assign uv_s  = syn_flags[NPAIR +: NSUP];
   assign otw_s = syn_flags[NPAIR+NSUP];
   assign ote_s = syn_flags[NPAIR+NSUP+1];
   assign por_s = syn_flags[NPAIR+NSUP+2];

   pg_ote_latch #(.NPAIR(NPAIR)) ote_latch_i (
      .clk(clk), .rst_n(rst_n), .ote(ote_s), .pair_rst_n(pair_rst_n), .ote_lat(ote_lat)
   );

   assign uv_any     = |uv_s;
   assign global_flt = ote_lat | uv_any | por_s;
   assign se_mode    = is_single_ended(mode);

   generate
      for (genvar p = 0; p < NPAIR; p++) begin : g_pair
         pg_olp_track #(.OLP_FRAMES(OLP_FRAMES)) olp_i (
            .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .oc(oc_s[p]),
            .pair_rst_n(pair_rst_n[p]), .hold(global_flt), .por(por_s), .olp(olp[p])
         );
         assign hiz_o[p]         = ~pair_rst_n[p] | olp[p] | global_flt;
         assign pulldown_en_o[p] = ~pair_rst_n[p] & ~se_mode;

         // R11
         pulldown_only_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
            pulldown_en_o[p] |-> hiz_o[p]);
      end
   endgenerate

   assign shutdown_n = ~(&pair_rst_n) | ~(|olp | global_flt);
   assign warn_n     = ~(otw_s | ote_lat);

   // R8
   uv_stops_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
      uv_any |-> (&hiz_o));
endmodule

// File: tb/pstage_guard_tb_top.sv
`timescale 1ns/1ps
module pstage_guard_tb_top;
   localparam int NPAIR = 2;
   localparam int NSUP  = 2;
   localparam int OLP   = 5;
   localparam int FLEN  = 8;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             tick = 1'b0;
   logic [NPAIR-1:0] oc = '0;
   logic             otw = 1'b0, ote = 1'b0, por = 1'b0;
   logic [NSUP-1:0]  uv = '0;
   logic [NPAIR-1:0] prst = '1;
   logic [2:0]       mode = 3'b000;
   logic [NPAIR-1:0] hiz, pd;
   logic             sd_n, wn;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   pstage_guard #(.NPAIR(NPAIR), .NSUP(NSUP), .OLP_FRAMES(OLP), .SYNC_STAGES(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .frame_tick(tick), .oc_flag(oc), .otw_flag(otw),
      .ote_flag(ote), .uv_flag(uv), .por_flag(por), .pair_rst_n(prst), .mode(mode),
      .hiz_o(hiz), .pulldown_en_o(pd), .shutdown_n(sd_n), .warn_n(wn)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
      end
   endtask

   // status word {hiz, sd_n, warn_n}
   function automatic logic [7:0] st();
      return {4'b0, hiz, sd_n, wn};
   endfunction

   task automatic wait_neg(input int n);
      repeat (n) @(negedge clk);
   endtask

   // oc_next lands in the synchronized flag exactly at this frame's tick edge
   task automatic do_frame(input logic [NPAIR-1:0] oc_next);
      repeat (FLEN-2) @(negedge clk);
      oc = oc_next;
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
   endtask

   task automatic pulse_rst(input logic [NPAIR-1:0] which);
      @(negedge clk); prst = ~which;
      @(negedge clk); prst = '1;
      @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      wait_neg(3);
      rst_n = 1'b1;
      wait_neg(3);
      // R1 reset state
      check("R1 status", st(), {4'b0, 2'b00, 2'b11});
      check("R1 pulldown", {6'b0, pd}, 8'h00);

      // R2 latency through the synchronizer
      @(negedge clk); uv = 2'b01;
      @(negedge clk);
      check("R2 one edge", st(), {4'b0, 2'b00, 2'b11});
      @(negedge clk);
      check("R2 two edges", st(), {4'b0, 2'b11, 2'b01});
      uv = '0; wait_neg(3);

      // R8 each supply flag, automatic release
      for (int s = 1; s < (1 << NSUP); s++) begin
         uv = NSUP'(s); wait_neg(3);
         check("R8 uv stop", st(), {4'b0, 2'b11, 2'b01});
         uv = '0; wait_neg(3);
         check("R8 uv release", st(), {4'b0, 2'b00, 2'b11});
      end

      // R12 warning follows the comparator
      otw = 1'b1; wait_neg(3);
      check("R12 warn on", st(), {4'b0, 2'b00, 2'b10});
      otw = 1'b0; wait_neg(2);
      check("R12 warn off", st(), {4'b0, 2'b00, 2'b11});

      // R9 status sweep over warning, undervoltage and power-on reset
      for (int v = 0; v < 8; v++) begin
         logic w, u, p, stop;
         w = v[0]; u = v[1]; p = v[2];
         otw = w; uv = {1'b0, u}; por = p;
         wait_neg(3);
         stop = u | p;
         check("R9 status sweep", st(), {4'b0, {2{stop}}, ~stop, ~w});
      end
      otw = 0; uv = '0; por = 0; wait_neg(3);

      // R3 run-length sweep on each pair, R5 clear by own reset
      for (int pr = 0; pr < NPAIR; pr++) begin
         for (int n = 1; n <= OLP + 1; n++) begin
            logic [NPAIR-1:0] ocv, exph;
            ocv = NPAIR'(1) << pr;
            do_frame(ocv);
            for (int k = 1; k <= n; k++) do_frame(k < n ? ocv : '0);
            exph = (n >= OLP) ? ocv : '0;
            check("R3 run length", st(), {4'b0, exph, (n < OLP), 1'b1});
            if (n >= OLP) begin
               pulse_rst(~ocv);
               check("R5 other reset keeps", st(), {4'b0, exph, 2'b01});
               @(negedge clk); prst = ~ocv;
               wait_neg(2);
               check("R10 sd forced high", {7'b0, sd_n}, 8'h01);
               prst = '1; wait_neg(1);
               check("R5 own reset clears", st(), {4'b0, 2'b00, 2'b11});
            end else begin
               do_frame('0);
            end
         end
      end

      // R4 a quiet frame restarts the count
      do_frame(2'b01);
      for (int k = 1; k <= OLP - 1; k++) do_frame(k == OLP - 1 ? 2'b00 : 2'b01);
      do_frame(2'b01);
      for (int k = 1; k <= OLP - 1; k++) do_frame(2'b01);
      check("R4 no latch after gap", st(), {4'b0, 2'b00, 2'b11});
      do_frame(2'b00);
      check("R4 latch on full run", st(), {4'b0, 2'b01, 2'b01});

      // R6 power-on reset stops all and clears the overload
      por = 1'b1; wait_neg(3);
      check("R6 por stop", st(), {4'b0, 2'b11, 2'b01});
      por = 1'b0; wait_neg(3);
      check("R6 por clears olp", st(), {4'b0, 2'b00, 2'b11});

      // R7 temperature error latch and its clearing rule
      ote = 1'b1; wait_neg(4);
      check("R7 ote stop", st(), {4'b0, 2'b11, 2'b00});
      ote = 1'b0; wait_neg(4);
      check("R7 ote held", st(), {4'b0, 2'b11, 2'b00});
      pulse_rst(2'b01);
      check("R7 one reset keeps", st(), {4'b0, 2'b11, 2'b00});
      pulse_rst(2'b10);
      check("R7 other reset keeps", st(), {4'b0, 2'b11, 2'b00});
      pulse_rst(2'b11);
      check("R7 both resets clear", st(), {4'b0, 2'b00, 2'b11});

      // R11 pulldown sweep over every mode code and reset combination
      for (int m = 0; m < 8; m++) begin
         for (int r = 0; r < 4; r++) begin
            logic [1:0] rv, ep;
            rv = 2'(r);
            @(negedge clk); mode = 3'(m); prst = rv;
            @(negedge clk);
            ep = (m == 4) ? 2'b00 : ~rv;
            check("R11 pulldown", {4'b0, pd, hiz}, {4'b0, ep, ~rv});
            check("R10 sd with reset", {7'b0, sd_n}, 8'h01);
         end
      end
      prst = '1; mode = 3'b000; wait_neg(2);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule